// File: doc/BRIEF.md
# Shadowed SRAM store/recall engine

This block models a byte-wide working memory paired with a nonvolatile shadow array of the same depth. It moves the whole array between the two copies. A store first erases the shadow copy and then programs it from the working array. A recall first clears the working array and then loads it from the shadow copy. Requests come from an external command detector as single-cycle pulses. A supply-status input makes a recall start by itself once power returns.

While a transfer runs, the engine holds `busy` high and the host port is shut: writes are dropped, reads do not update the read register, and the read data output shows zero. The phase being run and the address being transferred are exported so that the order of the work can be seen from outside. A host write that is still asserted in the final cycle of a power-up recall sets a sticky `corrupt` flag.

The address width `AW` sets the depth. A full-size instance uses `AW = 15`, giving 32K bytes in each copy. The default is kept small so that the register model stays cheap to elaborate. Phase durations are given in clock cycles. A program or load phase is never shorter than the depth, because it moves one byte per cycle.

Top module: `ssr_engine`

## Requirements
- R1: After reset, `busy`, `xfer_act`, `corrupt` and `host_rdata` are 0, `xfer_addr` is 0, and `phase` is 0 (idle).
- R2: When idle and `pwr_ok` is high, `host_en`=1 with `host_we`=1 writes `host_wdata` to `host_addr`. `host_en`=1 with `host_we`=0 reads `host_addr`, and the byte appears on `host_rdata` in the following cycle, where it is held until the next accepted read.
- R3: A `store_req` accepted while idle raises `busy` in the next cycle. `phase` is then 1 (erase) for `T_ERASE` cycles and 2 (program) for max(`T_PROG`, 2^AW) cycles, after which it returns to 0.
- R4: During program, the working array is copied into the shadow array one byte per cycle, in ascending address order starting at 0. `xfer_act` is 1 and `xfer_addr` gives the address for each of those 2^AW cycles. Load uses the same walk.
- R5: A `recall_req` accepted while idle gives `phase` 3 (clear) for `T_CLEAR` cycles and then 4 (load) for max(`T_LOAD`, 2^AW) cycles. Clear writes zero to every working byte, and load then copies the shadow array into the working array.
- R6: A recall never alters the shadow array, so repeated recalls each restore the same contents.
- R7: While `busy` is high, host writes leave the working array unchanged, host reads leave the read register unchanged, and `host_rdata` is 0.
- R8: Requests that arrive while busy are dropped. If `store_req` and `recall_req` arrive in the same idle cycle, the store is taken.
- R9: While `pwr_ok` is low, a recall request is latched, and host accesses and request pulses are ignored. In the first cycle in which `pwr_ok` is high while idle, the latched recall starts, and `phase` reads 3 in the next cycle. This recall takes precedence over both request inputs.
- R10: A host write (`host_en` and `host_we` both high) in the final load cycle of a power-up recall sets `corrupt` in the next cycle, and it stays set until reset. The same write during a requested recall leaves `corrupt` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Supply above threshold |
| store_req | input | 1 | Store request pulse |
| recall_req | input | 1 | Recall request pulse |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | AW | Host byte address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Registered read data, 0 while busy |
| busy | output | 1 | Transfer in progress |
| phase | output | 3 | 0 idle, 1 erase, 2 program, 3 clear, 4 load |
| xfer_act | output | 1 | A byte is moved this cycle |
| xfer_addr | output | AW | Address of the byte being moved |
| corrupt | output | 1 | Write overlapped end of power-up recall |

## Verification
The assertions check on every cycle that the phase order is legal: erase leads only to program, clear leads only to load, and idle leads only to a first phase. They also check that the transfer address climbs by one from zero, that the shadow array is written only in program, and that the host cannot write the working array while busy. They further check that a pending power recall starts at once, and that `corrupt` is sticky and rises only out of a load phase. Data integrity is shown only by the bench scenarios, which compare against a behavioural model of both arrays. These scenarios cover the round trip of a store followed by recalls, writes dropped during busy or power loss, the store-over-recall tie, and the difference in `corrupt` between a requested recall and a power-up recall.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ERASE = 3'd1,
    PH_PROG  = 3'd2,
    PH_CLEAR = 3'd3,
    PH_LOAD  = 3'd4
  } phase_e;
endpackage

// File: rtl/ssr_mem.sv
// Byte array model with a whole-array fill and one write / one read port.
module ssr_mem #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          fill_en,
  input  logic [DW-1:0] fill_val,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (fill_en) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= fill_val;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/ssr_ctrl.sv
// Phase sequencer: erase->program for store, clear->load for recall (R3, R5).
module ssr_ctrl
  import ssr_pkg::*;
#(
  parameter int AW      = 6,
  parameter int T_ERASE = 5,
  parameter int T_PROG  = 70,
  parameter int T_CLEAR = 3,
  parameter int T_LOAD  = 66
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_ok,
  input  logic          store_req,
  input  logic          recall_req,
  output phase_e        phase,
  output logic [AW-1:0] xfer_addr,
  output logic          xfer_act,
  output logic          first_cyc,
  output logic          last_cyc,
  output logic          pwr_op,
  output logic          pend
);
  localparam int DEPTH     = 1 << AW;
  localparam int ERASE_LEN = (T_ERASE < 1) ? 1 : T_ERASE;
  localparam int PROG_LEN  = (T_PROG < DEPTH) ? DEPTH : T_PROG;
  localparam int CLEAR_LEN = (T_CLEAR < 1) ? 1 : T_CLEAR;
  localparam int LOAD_LEN  = (T_LOAD < DEPTH) ? DEPTH : T_LOAD;
  localparam int MAX_SE    = (ERASE_LEN > PROG_LEN) ? ERASE_LEN : PROG_LEN;
  localparam int MAX_RC    = (CLEAR_LEN > LOAD_LEN) ? CLEAR_LEN : LOAD_LEN;
  localparam int MAX_LEN   = (MAX_SE > MAX_RC) ? MAX_SE : MAX_RC;
  localparam int CW        = $clog2(MAX_LEN + 1);

  localparam logic [CW-1:0] ERASE_LAST = CW'(ERASE_LEN - 1);
  localparam logic [CW-1:0] PROG_LAST  = CW'(PROG_LEN - 1);
  localparam logic [CW-1:0] CLEAR_LAST = CW'(CLEAR_LEN - 1);
  localparam logic [CW-1:0] LOAD_LAST  = CW'(LOAD_LEN - 1);
  localparam logic [CW-1:0] DEPTH_C    = CW'(DEPTH);

  phase_e          phase_q, phase_d;
  logic [CW-1:0]   cnt_q, cnt_d, cur_last;
  logic            pend_q, pend_d;
  logic            pwr_op_q, pwr_op_d;
  logic            cnt_en;

  always_comb begin
    case (phase_q)
      PH_ERASE: cur_last = ERASE_LAST;
      PH_PROG:  cur_last = PROG_LAST;
      PH_CLEAR: cur_last = CLEAR_LAST;
      PH_LOAD:  cur_last = LOAD_LAST;
      default:  cur_last = '0;
    endcase
  end

  assign last_cyc = (phase_q != PH_IDLE) && (cnt_q == cur_last);
  assign cnt_en   = (phase_q != PH_IDLE);

  // Next state. Power-up recall beats store, and store beats recall (R8, R9).
  always_comb begin
    phase_d  = phase_q;
    pwr_op_d = pwr_op_q;
    pend_d   = pend_q | ~pwr_ok;
    cnt_d    = last_cyc ? '0 : cnt_q + 1'b1;
    case (phase_q)
      PH_IDLE: begin
        if (pwr_ok) begin
          if (pend_q) begin
            phase_d  = PH_CLEAR;
            pwr_op_d = 1'b1;
            pend_d   = 1'b0;
          end else if (store_req) begin
            phase_d  = PH_ERASE;
            pwr_op_d = 1'b0;
          end else if (recall_req) begin
            phase_d  = PH_CLEAR;
            pwr_op_d = 1'b0;
          end
        end
      end
      PH_ERASE: if (last_cyc) phase_d = PH_PROG;
      PH_PROG:  if (last_cyc) phase_d = PH_IDLE;
      PH_CLEAR: if (last_cyc) phase_d = PH_LOAD;
      PH_LOAD:  if (last_cyc) phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      pend_q   <= 1'b0;
      pwr_op_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      pend_q   <= pend_d;
      pwr_op_q <= pwr_op_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  // R4: one address per cycle, ascending, during the first DEPTH cycles.
  assign xfer_act  = ((phase_q == PH_PROG) || (phase_q == PH_LOAD)) && (cnt_q < DEPTH_C);
  assign xfer_addr = xfer_act ? cnt_q[AW-1:0] : '0;
  assign first_cyc = (cnt_q == '0);
  assign phase     = phase_q;
  assign pwr_op    = pwr_op_q;
  assign pend      = pend_q;
endmodule

// File: rtl/ssr_host.sv
// Host port: gated writes, registered reads, corruption flag (R2, R7, R10).
module ssr_host #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_ok,
  input  logic          host_en,
  input  logic          host_we,
  input  logic          busy,
  input  logic          pwr_last_load,
  input  logic [DW-1:0] arr_rdata,
  output logic          arr_host_we,
  output logic [DW-1:0] host_rdata,
  output logic          corrupt
);
  logic [DW-1:0] rd_q, rd_d;
  logic          rd_en;
  logic          cor_q, cor_d;

  assign arr_host_we = host_ok & host_en & host_we;
  assign rd_en       = host_ok & host_en & ~host_we;

  always_comb begin
    rd_d  = arr_rdata;
    cor_d = cor_q | (pwr_last_load & host_en & host_we);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      cor_q <= 1'b0;
    end else begin
      if (rd_en) rd_q <= rd_d;
      cor_q <= cor_d;
    end
  end

  assign host_rdata = busy ? '0 : rd_q;
  assign corrupt    = cor_q;
endmodule

// File: rtl/ssr_engine.sv
module ssr_engine
  import ssr_pkg::*;
#(
  parameter int AW      = 6,
  parameter int DW      = 8,
  parameter int T_ERASE = 5,
  parameter int T_PROG  = 70,
  parameter int T_CLEAR = 3,
  parameter int T_LOAD  = 66
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_ok,
  input  logic          store_req,
  input  logic          recall_req,
  input  logic          host_en,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          busy,
  output logic [2:0]    phase,
  output logic          xfer_act,
  output logic [AW-1:0] xfer_addr,
  output logic          corrupt
);
  phase_e        ph;
  logic          first_cyc, last_cyc, pwr_op, pend;
  logic          host_ok, host_wr;
  logic          work_we, work_fill, shd_we, shd_fill;
  logic [AW-1:0] work_addr;
  logic [DW-1:0] work_wdata, work_rdata, shd_rdata;

  ssr_ctrl #(
    .AW(AW), .T_ERASE(T_ERASE), .T_PROG(T_PROG), .T_CLEAR(T_CLEAR), .T_LOAD(T_LOAD)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok),
    .store_req(store_req), .recall_req(recall_req),
    .phase(ph), .xfer_addr(xfer_addr), .xfer_act(xfer_act),
    .first_cyc(first_cyc), .last_cyc(last_cyc), .pwr_op(pwr_op), .pend(pend)
  );

  assign busy    = (ph != PH_IDLE);
  assign host_ok = ~busy & pwr_ok;

  ssr_host #(.DW(DW)) u_host (
    .clk(clk), .rst_n(rst_n), .host_ok(host_ok),
    .host_en(host_en), .host_we(host_we), .busy(busy),
    .pwr_last_load(last_cyc & pwr_op & (ph == PH_LOAD)),
    .arr_rdata(work_rdata), .arr_host_we(host_wr),
    .host_rdata(host_rdata), .corrupt(corrupt)
  );

  // Working array: host port when idle, clear/load when busy (R5, R7).
  assign work_fill  = (ph == PH_CLEAR) & first_cyc;
  assign work_we    = host_wr | (xfer_act & (ph == PH_LOAD));
  assign work_addr  = busy ? xfer_addr : host_addr;
  assign work_wdata = busy ? shd_rdata : host_wdata;

  // Shadow array: erased then programmed; untouched by recall (R6).
  assign shd_fill = (ph == PH_ERASE) & first_cyc;
  assign shd_we   = xfer_act & (ph == PH_PROG);

  ssr_mem #(.AW(AW), .DW(DW)) u_work (
    .clk(clk), .fill_en(work_fill), .fill_val('0),
    .we(work_we), .waddr(work_addr), .wdata(work_wdata),
    .raddr(work_addr), .rdata(work_rdata)
  );

  ssr_mem #(.AW(AW), .DW(DW)) u_shd (
    .clk(clk), .fill_en(shd_fill), .fill_val('1),
    .we(shd_we), .waddr(xfer_addr), .wdata(work_rdata),
    .raddr(xfer_addr), .rdata(shd_rdata)
  );

  assign phase = ph;
endmodule

// File: rtl/ssr_engine_chk.sv
module ssr_engine_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    phase,
  input logic          busy,
  input logic          xfer_act,
  input logic [AW-1:0] xfer_addr,
  input logic          shd_we,
  input logic          work_we,
  input logic          pend,
  input logic          pwr_ok,
  input logic          corrupt
);
  a_r3_erase_then_prog: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1) |=> (phase == 3'd1 || phase == 3'd2));
  a_r3_prog_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd2) |=> (phase == 3'd2 || phase == 3'd0));
  a_r5_clear_then_load: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd3) |=> (phase == 3'd3 || phase == 3'd4));
  a_r5_load_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd4) |=> (phase == 3'd4 || phase == 3'd0));
  a_r8_start_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (phase == 3'd1 || phase == 3'd3));
  a_r4_walk_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_act) |-> (xfer_addr == '0));
  a_r4_walk_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_act && $past(xfer_act)) |-> (xfer_addr == AW'($past(xfer_addr) + 1'b1)));
  a_r6_shadow_prog_only: assert property (@(posedge clk) disable iff (!rst_n)
    shd_we |-> (phase == 3'd2));
  a_r7_no_host_write: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && work_we) |-> (phase == 3'd4));
  a_r9_power_recall: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0 && pend && pwr_ok) |=> (phase == 3'd3));
  a_r10_corrupt_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(corrupt) |-> ($past(phase) == 3'd4));
  a_r10_corrupt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    corrupt |=> corrupt);
endmodule

bind ssr_engine ssr_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .busy(busy),
  .xfer_act(xfer_act), .xfer_addr(xfer_addr), .shd_we(shd_we),
  .work_we(work_we), .pend(pend), .pwr_ok(pwr_ok), .corrupt(corrupt)
);

// File: tb/sim_ssr_engine.sv
`timescale 1ns/1ps
module sim_ssr_engine;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int TE = 5;
  localparam int TP = 70;
  localparam int TC = 3;
  localparam int TL = 66;
  localparam int PL = (TP < DEPTH) ? DEPTH : TP;
  localparam int LL = (TL < DEPTH) ? DEPTH : TL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b1;
  logic store_req = 1'b0, recall_req = 1'b0;
  logic host_en = 1'b0, host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic busy, xfer_act, corrupt;
  logic [2:0] phase;
  logic [AW-1:0] xfer_addr;

  always #5 clk = ~clk;

  ssr_engine #(.AW(AW), .DW(DW), .T_ERASE(TE), .T_PROG(TP), .T_CLEAR(TC), .T_LOAD(TL)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .store_req(store_req), .recall_req(recall_req),
    .host_en(host_en), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .busy(busy), .phase(phase), .xfer_act(xfer_act),
    .xfer_addr(xfer_addr), .corrupt(corrupt)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pat_a(input int a);
    return (a * 37 + 11) & 255;
  endfunction

  // ---------------- behavioural reference model ----------------
  int wk[DEPTH];
  int sh[DEPTH];
  int m_mode, m_tick, m_pend, m_pwrop, m_rd, m_cor;

  initial for (int i = 0; i < DEPTH; i++) begin wk[i] = 0; sh[i] = 0; end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_tick = 0; m_pend = 0; m_pwrop = 0; m_rd = 0; m_cor = 0;
    end else begin
      if (m_mode == 1) begin
        if (m_tick == 0) for (int i = 0; i < DEPTH; i++) sh[i] = 255;
        if (m_tick >= TE && m_tick - TE < DEPTH) sh[m_tick - TE] = wk[m_tick - TE];
        m_tick++;
        if (m_tick == TE + PL) m_mode = 0;
      end else if (m_mode == 2) begin
        if (m_tick == 0) for (int i = 0; i < DEPTH; i++) wk[i] = 0;
        if (m_tick >= TC && m_tick - TC < DEPTH) wk[m_tick - TC] = sh[m_tick - TC];
        if (m_tick == TC + LL - 1 && m_pwrop == 1 && host_en && host_we) m_cor = 1;
        m_tick++;
        if (m_tick == TC + LL) m_mode = 0;
      end else if (pwr_ok) begin
        if (host_en && host_we) wk[host_addr] = host_wdata;
        if (host_en && !host_we) m_rd = wk[host_addr];
        if (m_pend == 1) begin m_mode = 2; m_pwrop = 1; m_pend = 0; m_tick = 0; end
        else if (store_req) begin m_mode = 1; m_pwrop = 0; m_tick = 0; end
        else if (recall_req) begin m_mode = 2; m_pwrop = 0; m_tick = 0; end
      end
      if (!pwr_ok) m_pend = 1;
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e_ph, e_act, e_addr;
      e_ph = 0; e_act = 0; e_addr = 0;
      if (m_mode == 1) begin
        e_ph = (m_tick < TE) ? 1 : 2;
        if (m_tick >= TE && m_tick - TE < DEPTH) begin e_act = 1; e_addr = m_tick - TE; end
      end else if (m_mode == 2) begin
        e_ph = (m_tick < TC) ? 3 : 4;
        if (m_tick >= TC && m_tick - TC < DEPTH) begin e_act = 1; e_addr = m_tick - TC; end
      end
      chk(int'(busy) == (m_mode != 0 ? 1 : 0), "R3 busy", int'(busy), (m_mode != 0) ? 1 : 0);
      chk(int'(phase) == e_ph, "R3/R5 phase", int'(phase), e_ph);
      chk(int'(xfer_act) == e_act, "R4 xfer_act", int'(xfer_act), e_act);
      chk(int'(xfer_addr) == e_addr, "R4 xfer_addr", int'(xfer_addr), e_addr);
      chk(int'(host_rdata) == ((m_mode != 0) ? 0 : m_rd), "R2/R7 host_rdata",
          int'(host_rdata), (m_mode != 0) ? 0 : m_rd);
      chk(int'(corrupt) == m_cor, "R10 corrupt", int'(corrupt), m_cor);
    end
  end

  // ---------------- stimulus tasks (entered just after a negedge) ----------------
  task automatic wr(input int a, input int d);
    host_en = 1'b1; host_we = 1'b1; host_addr = AW'(a); host_wdata = DW'(d);
    @(negedge clk);
    host_en = 1'b0; host_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    host_en = 1'b1; host_we = 1'b0; host_addr = AW'(a);
    @(negedge clk);
    host_en = 1'b0;
    d = int'(host_rdata);
  endtask

  task automatic pulse(input bit st, input bit rc);
    store_req = st; recall_req = rc;
    @(negedge clk);
    store_req = 1'b0; recall_req = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic write_at_last_load();
    while (phase != 3'd4) @(negedge clk);
    repeat (LL - 1) @(negedge clk);
    wr(0, 8'hC3);
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(phase == 3'd0, "R1 phase", int'(phase), 0);
    chk(host_rdata == '0, "R1 rdata", int'(host_rdata), 0);
    chk(corrupt == 1'b0, "R1 corrupt", int'(corrupt), 0);
    chk(xfer_act == 1'b0, "R1 xfer_act", int'(xfer_act), 0);

    // R2: fill and read back
    for (int a = 0; a < DEPTH; a++) wr(a, pat_a(a));
    for (int a = 0; a < DEPTH; a += 9) begin
      rd(a, d); chk(d == pat_a(a), "R2 readback", d, pat_a(a));
    end

    // R3: store; R7/R8 traffic while busy
    pulse(1'b1, 1'b0);
    chk(phase == 3'd1, "R3 erase first", int'(phase), 1);
    wr(5, 8'h55);
    rd(6, d); chk(d == 0, "R7 rdata quiet", d, 0);
    pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b0);
    wait_idle();
    rd(5, d); chk(d == pat_a(5), "R7 write ignored", d, pat_a(5));

    // R5: overwrite then recall restores stored pattern
    for (int a = 0; a < DEPTH; a++) wr(a, a ^ 8'h5A);
    pulse(1'b0, 1'b1);
    chk(phase == 3'd3, "R5 clear first", int'(phase), 3);
    wait_idle();
    for (int a = 0; a < DEPTH; a += 5) begin
      rd(a, d); chk(d == pat_a(a), "R5 recall data", d, pat_a(a));
    end

    // R6: repeated recall, with R10 negative (software recall)
    for (int a = 0; a < DEPTH; a += 3) wr(a, 8'h77);
    pulse(1'b0, 1'b1);
    write_at_last_load();
    @(negedge clk);
    chk(corrupt == 1'b0, "R10 no flag on requested recall", int'(corrupt), 0);
    for (int a = 0; a < DEPTH; a += 3) begin
      rd(a, d); chk(d == pat_a(a), "R6 repeat recall", d, pat_a(a));
    end

    // R8: simultaneous requests, store wins
    pulse(1'b1, 1'b1);
    chk(phase == 3'd1, "R8 store wins", int'(phase), 1);
    wait_idle();

    // R9: power loss
    wr(1, 8'h11);
    rd(1, d); chk(d == 8'h11, "R2 write when idle", d, 8'h11);
    pwr_ok = 1'b0;
    @(negedge clk);
    wr(1, 8'hEE);
    rd(3, d); chk(d == 8'h11, "R9 read ignored", d, 8'h11);
    pulse(1'b1, 1'b0);
    chk(busy == 1'b0, "R9 request ignored", int'(busy), 0);
    pwr_ok = 1'b1;
    @(negedge clk);
    chk(phase == 3'd3, "R9 auto recall", int'(phase), 3);
    write_at_last_load();
    chk(corrupt == 1'b1, "R10 flag on power recall", int'(corrupt), 1);
    rd(1, d); chk(d == pat_a(1), "R9 recall data", d, pat_a(1));
    rd(0, d); chk(d == pat_a(0), "R7 final-cycle write ignored", d, pat_a(0));
    repeat (4) @(negedge clk);
    chk(corrupt == 1'b1, "R10 sticky", int'(corrupt), 1);
    finish_up();
  end
endmodule